// File: doc/BRIEF.md
# Infomax Learning Nonlinearity Unit

This block evaluates the odd learning nonlinearity phi(u) = (1 - e^(-u)) / (1 + e^(-u)) for one neuron of an independent-component learning network. It takes a signed fixed-point synaptic input and returns a signed fixed-point result. Both shape constants of the underlying sigmoid are fixed at one. The function is odd, so the datapath works on |u| and applies the input's sign to the result at the end.

Evaluation runs in arithmetic and uses no sampled function table. Range reduction first writes |u| = k*ln2 + r, with k the nearest integer to |u|/ln2, which leaves r in [-ln2/2, +ln2/2]. Eight radix-4 normalization steps then form e^(-r) by shift-and-add. Each step picks a digit in -2..2 and folds a stored constant ln(1 + d*4^-j) into the residual. Shifting right by k restores e^(-|u|). A 16-entry seed table and two Newton-Raphson steps produce the reciprocal of 1 + e^(-|u|), and one multiply by 1 - e^(-|u|) finishes the quotient.

Only one operation is in flight at a time. The unit raises ready when idle, takes one input on a valid-and-ready edge, and signals completion with a single-cycle valid pulse.

Top module: `infomax_phi`

## Requirements
- R1: While rst_ni is low and right after it rises, out_valid_o is 0, out_data_o is 0 and in_ready_o is 1.
- R2: in_data_i is two's complement with 12 fraction bits (u = code/4096), and out_data_o is two's complement with 14 fraction bits. Each result is within 4 LSB of round(16384 * (1 - e^(-u)) / (1 + e^(-u))).
- R3: For every code c other than -32768, the result for -c is the exact two's complement negation of the result for c.
- R4: Every result lies in [-16383, +16383]. Values that round beyond this range saturate to the bound.
- R5: An input code of 0 gives a result of exactly 0.
- R6: in_ready_o is high exactly when no operation is in flight. An input is taken on a rising edge where in_valid_i and in_ready_o are both high, and in_ready_o is low in the next cycle. in_valid_i and in_data_i are ignored while an operation is in flight.
- R7: Each accepted input produces exactly one out_valid_o pulse, and that pulse lasts a single cycle.
- R8: From the accepting edge to the edge that raises out_valid_o takes 14 + k rising edges, where k is the range-reduction count (0 for a zero input). The latency never exceeds 26 edges.
- R9: out_data_o changes only on the edge that raises out_valid_o, and it holds the last result between pulses.
- R10: The most negative code, -32768 (u = -8.0), is handled through its 17-bit magnitude. Its result is within 4 LSB of -16373.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input code offered |
| in_ready_o | output | 1 | Unit idle and able to take an input |
| in_data_i | input | 16 | Synaptic input, signed, 12 fraction bits |
| out_valid_o | output | 1 | One-cycle pulse marking a new result |
| out_data_o | output | 16 | Result, signed, 14 fraction bits, held between pulses |

## Verification
The case hardest to reach from the ports is the extreme of range reduction. The code -32768 needs a 17-bit magnitude and takes the longest subtraction loop (k = 12), so the bench applies it directly as its own vector. The opposite extreme, where e^(-|u|) lands on or just below one, is reached by the zero input and by the smallest nonzero codes in a sweep that walks every magnitude stride with a varying low-order offset. Each magnitude is applied as a pair, c and then -c, so symmetry is compared result against result. To show that the input is ignored while busy, the bench holds in_valid_i high with a different code for the whole time an operation is in flight. It then checks both the returned value and that no extra operation was started.

// File: rtl/phi_pkg.sv
`timescale 1ns/1ps
package phi_pkg;

  localparam int FRAC_DEF  = 20;
  localparam int W_DEF     = 26;
  localparam int STEPS_DEF = 8;
  localparam int SEED_DEF  = 4;
  localparam int K_W_DEF   = 5;
  localparam int N_DIG     = 5;

  function automatic int rnd(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  // ln(1 + d * 4^-step) scaled by 2^frac
  function automatic int ln_fix(int step, int d, int frac);
    real z;
    z = 1.0 + real'(d) / (4.0 ** step);
    return rnd($ln(z) * (2.0 ** frac));
  endfunction

  function automatic int ln2_fix(int frac);
    return rnd($ln(2.0) * (2.0 ** frac));
  endfunction

  // reciprocal of the midpoint of seed bin idx over [1,2)
  function automatic int seed_fix(int idx, int bits, int frac);
    real mid;
    mid = 1.0 + (real'(idx) + 0.5) / (2.0 ** bits);
    return rnd((2.0 ** frac) / mid);
  endfunction

endpackage

// File: rtl/phi_range_red.sv
`timescale 1ns/1ps
module phi_range_red #(
  parameter int W    = phi_pkg::W_DEF,
  parameter int FRAC = phi_pkg::FRAC_DEF,
  parameter int K_W  = phi_pkg::K_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] mag_i,
  output logic                done_o,
  output logic signed [W-1:0] r_o,
  output logic [K_W-1:0]      k_o
);

  localparam logic signed [W-1:0] LN2      = W'(phi_pkg::ln2_fix(FRAC));
  localparam logic signed [W-1:0] LN2_HALF = LN2 >>> 1;

  logic signed [W-1:0] r_q;
  logic [K_W-1:0]      k_q;
  logic                busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q    <= '0;
      k_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        r_q    <= mag_i;
        k_q    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        // round-to-nearest k: stop once r is within half of ln2
        if (r_q > LN2_HALF) begin
          r_q <= r_q - LN2;
          k_q <= k_q + K_W'(1);
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign r_o    = r_q;
  assign k_o    = k_q;

endmodule

// File: rtl/phi_exp_r4.sv
`timescale 1ns/1ps
module phi_exp_r4 #(
  parameter int W       = phi_pkg::W_DEF,
  parameter int FRAC    = phi_pkg::FRAC_DEF,
  parameter int N_STEPS = phi_pkg::STEPS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] x_i,
  output logic                done_o,
  output logic signed [W-1:0] y_o
);

  localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
  localparam int SH_W   = $clog2(2 * N_STEPS + 3);
  localparam int NT     = phi_pkg::N_DIG - 1;
  localparam logic signed [W-1:0] ONE = W'(1 << FRAC);

  logic signed [W-1:0] ln_tab [N_STEPS][phi_pkg::N_DIG];

  for (genvar gs = 0; gs < N_STEPS; gs++) begin : g_step
    for (genvar gd = 0; gd < phi_pkg::N_DIG; gd++) begin : g_dig
      localparam int LV = phi_pkg::ln_fix(gs + 1, gd - 2, FRAC);
      assign ln_tab[gs][gd] = W'(LV);
    end
  end

  logic signed [W-1:0] x_q, y_q;
  logic [STEP_W-1:0]   step_q;
  logic                busy_q, done_q;

  logic signed [W-1:0] thr [NT];
  logic [2:0]          dsel;
  logic signed [W-1:0] ln_sel, ymul, delta;
  logic [SH_W-1:0]     shamt;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      thr[i] = (ln_tab[step_q][i] + ln_tab[step_q][i+1]) >>> 1;
    end
    dsel = '0;
    for (int i = 0; i < NT; i++) begin
      if (x_q > thr[i]) dsel = dsel + 3'd1;
    end
    ln_sel = ln_tab[step_q][dsel];
    unique case (dsel)
      3'd0:    ymul = -(y_q <<< 1);
      3'd1:    ymul = -y_q;
      3'd3:    ymul = y_q;
      3'd4:    ymul = y_q <<< 1;
      default: ymul = '0;
    endcase
    shamt = SH_W'({step_q, 1'b0}) + SH_W'(2);
    delta = ymul >>> shamt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        x_q    <= x_i;
        y_q    <= ONE;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        x_q    <= x_q - ln_sel;
        y_q    <= y_q + delta;
        step_q <= step_q + STEP_W'(1);
        if (step_q == STEP_W'(N_STEPS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign y_o    = y_q;

endmodule

// File: rtl/phi_recip_nr.sv
`timescale 1ns/1ps
module phi_recip_nr #(
  parameter int W         = phi_pkg::W_DEF,
  parameter int FRAC      = phi_pkg::FRAC_DEF,
  parameter int SEED_BITS = phi_pkg::SEED_DEF,
  parameter int N_ITER    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] den_i,
  output logic                done_o,
  output logic signed [W-1:0] rcp_o
);

  localparam int N_SEED = 2 ** SEED_BITS;
  localparam int IT_W   = (N_ITER > 1) ? $clog2(N_ITER) : 1;
  localparam logic signed [W-1:0] TWO = W'(2 << FRAC);

  logic signed [W-1:0] seed_tab [N_SEED];

  for (genvar gi = 0; gi < N_SEED; gi++) begin : g_seed
    localparam int SV = phi_pkg::seed_fix(gi, SEED_BITS, FRAC);
    assign seed_tab[gi] = W'(SV);
  end

  logic signed [W-1:0]   d_q, x_q;
  logic [IT_W-1:0]       it_q;
  logic                  busy_q, done_q;
  logic [SEED_BITS-1:0]  idx;
  logic signed [2*W-1:0] dx, xe;
  logic signed [W-1:0]   t, corr, x_next;

  // den of exactly 2 falls in the top bin
  assign idx = (den_i >= TWO) ? '1 : den_i[FRAC-1 -: SEED_BITS];

  always_comb begin
    dx     = d_q * x_q;
    t      = W'(dx >>> FRAC);
    corr   = TWO - t;
    xe     = x_q * corr;
    x_next = W'(xe >>> FRAC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q    <= '0;
      x_q    <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        d_q    <= den_i;
        x_q    <= seed_tab[idx];
        it_q   <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        x_q  <= x_next;
        it_q <= it_q + IT_W'(1);
        if (it_q == IT_W'(N_ITER - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rcp_o  = x_q;

endmodule

// File: rtl/infomax_phi.sv
`timescale 1ns/1ps
module infomax_phi #(
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 12,
  parameter int OUT_W     = 16,
  parameter int OUT_FRAC  = 14,
  parameter int FRAC      = phi_pkg::FRAC_DEF,
  parameter int W         = phi_pkg::W_DEF,
  parameter int N_STEPS   = phi_pkg::STEPS_DEF,
  parameter int SEED_BITS = phi_pkg::SEED_DEF,
  parameter int K_W       = phi_pkg::K_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);

  localparam int SH_IN   = FRAC - IN_FRAC;
  localparam int SH_OUT  = 2 * FRAC - OUT_FRAC;
  localparam int OUT_MAX = (1 << OUT_FRAC) - 1;
  localparam logic signed [W-1:0]     ONE = W'(1 << FRAC);
  localparam logic signed [2*W-1:0]   RND = (2*W)'(1) <<< (SH_OUT - 1);
  localparam logic signed [OUT_W-1:0] SAT = OUT_W'(OUT_MAX);

  logic busy_q, neg_q, accept;
  logic [K_W-1:0]      k_q;
  logic signed [W-1:0] num_q;

  logic signed [IN_W:0] in_ext, in_mag;
  logic signed [W-1:0]  mag_w;

  logic                red_done, exp_done, rcp_done;
  logic signed [W-1:0] red_r, exp_y, rcp;
  logic [K_W-1:0]      red_k;
  logic signed [W-1:0] e_sh, e_cl, num_d, den_d;

  logic signed [2*W-1:0]   prod, mag_full;
  logic signed [OUT_W-1:0] mag_sat, res_d;
  logic                    out_valid_q;
  logic [OUT_W-1:0]        out_q;

  assign accept = in_valid_i & ~busy_q;

  always_comb begin
    in_ext = {in_data_i[IN_W-1], in_data_i};
    in_mag = in_data_i[IN_W-1] ? -in_ext : in_ext;
    mag_w  = W'(in_mag) <<< SH_IN;
  end

  phi_range_red #(.W(W), .FRAC(FRAC), .K_W(K_W)) u_red (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .mag_i  (mag_w),
    .done_o (red_done),
    .r_o    (red_r),
    .k_o    (red_k)
  );

  // residual starts at -r so the product converges to e^(-r)
  phi_exp_r4 #(.W(W), .FRAC(FRAC), .N_STEPS(N_STEPS)) u_exp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(red_done),
    .x_i    (-red_r),
    .done_o (exp_done),
    .y_o    (exp_y)
  );

  always_comb begin
    e_sh  = exp_y >>> k_q;
    e_cl  = (e_sh > ONE) ? ONE : e_sh;
    num_d = ONE - e_cl;
    den_d = ONE + e_cl;
  end

  phi_recip_nr #(.W(W), .FRAC(FRAC), .SEED_BITS(SEED_BITS), .N_ITER(2)) u_rcp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(exp_done),
    .den_i  (den_d),
    .done_o (rcp_done),
    .rcp_o  (rcp)
  );

  always_comb begin
    prod     = num_q * rcp;
    mag_full = (prod + RND) >>> SH_OUT;
    mag_sat  = (mag_full > (2*W)'(OUT_MAX)) ? SAT : OUT_W'(mag_full);
    res_d    = neg_q ? -mag_sat : mag_sat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      neg_q       <= 1'b0;
      k_q         <= '0;
      num_q       <= '0;
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else begin
      out_valid_q <= rcp_done;
      if (accept) begin
        busy_q <= 1'b1;
        neg_q  <= in_data_i[IN_W-1];
      end else if (rcp_done) begin
        busy_q <= 1'b0;
      end
      if (red_done) k_q   <= red_k;
      if (exp_done) num_q <= num_d;
      if (rcp_done) out_q <= res_d;
    end
  end

  assign in_ready_o  = ~busy_q;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_q;

endmodule

// File: rtl/phi_checker.sv
`timescale 1ns/1ps
module phi_checker #(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 14,
  parameter int LAT_MAX  = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [IN_W-1:0]  in_data_i,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_data_o
);

  localparam int OUT_MAX = (1 << OUT_FRAC) - 1;

  logic            flight_q;
  logic [7:0]      lat_q;
  logic [IN_W-1:0] last_in_q;
  logic            acc;

  assign acc = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flight_q  <= 1'b0;
      lat_q     <= '0;
      last_in_q <= '0;
    end else if (acc) begin
      flight_q  <= 1'b1;
      lat_q     <= '0;
      last_in_q <= in_data_i;
    end else if (out_valid_o) begin
      flight_q <= 1'b0;
    end else if (flight_q) begin
      lat_q <= lat_q + 8'd1;
    end
  end

  p_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($signed(out_data_o) <= OUT_MAX && $signed(out_data_o) >= -OUT_MAX));

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && last_in_q == '0) |-> out_data_o == '0);

  p_ready_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !in_ready_o);

  p_idle_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flight_q |-> in_ready_o);

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_owned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> flight_q);

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> int'(lat_q) <= LAT_MAX);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));

endmodule

bind infomax_phi phi_checker #(
  .IN_W(IN_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o)
);

// File: tb/infomax_phi_bench.sv
`timescale 1ns/1ps
module infomax_phi_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int n_acc = 0;
  int n_pulse = 0;

  always #2.5 clk = ~clk;

  infomax_phi u_infomax_phi (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  always @(negedge clk) if (rst_n && out_valid) n_pulse++;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic int model(input int u);
    real x, e, v;
    int  r;
    x = real'(u) / 4096.0;
    e = $exp(-x);
    v = 16384.0 * (1.0 - e) / (1.0 + e);
    r = (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    if (r > 16383) r = 16383;
    if (r < -16383) r = -16383;
    return r;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic run_op(input int u, input bit inject, output int res, output int lat);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = u[15:0];
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    n_acc++;
    lat = 0;
    @(negedge clk);
    in_valid = 1'b0;
    if (inject) begin
      chk(!in_ready, "R6 ready low after accept", int'(in_ready), 0);
      in_valid = 1'b1;
      in_data  = 16'h6000;
    end
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (out_valid || lat > 60) break;
    end
    in_valid = 1'b0;
    res = int'($signed(out_data));
    @(negedge clk);
    chk(!out_valid, "R7 single-cycle pulse", int'(out_valid), 0);
  endtask

  task automatic check_val(input int u, input int res, input int lat);
    int exp_v;
    exp_v = model(u);
    chk(iabs(res - exp_v) <= 4, "R2 within 4 LSB", res, exp_v);
    chk(res <= 16383 && res >= -16383, "R4 magnitude bound", res, 16383);
    chk(lat >= 14 && lat <= 26, "R8 latency window", lat, 26);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    finish_run();
  end

  initial begin
    int res, lat, rp, rn, lp, ln, hold;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(out_data == 16'd0, "R1 out_data in reset", int'(out_data), 0);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset",
        int'({in_ready, out_valid}), 2);

    // R5 zero input, R8 k = 0 latency
    run_op(0, 1'b0, res, lat);
    chk(res == 0, "R5 zero gives zero", res, 0);
    chk(lat == 14, "R8 latency for zero input", lat, 14);

    // R2/R3/R4/R8 sweep in +/- pairs
    for (int i = 0; i < 2048; i++) begin
      int u;
      u = i * 16 + (i & 15);
      run_op(u, 1'b0, rp, lp);
      check_val(u, rp, lp);
      run_op(-u, 1'b0, rn, ln);
      check_val(-u, rn, ln);
      chk(rn == -rp, "R3 odd symmetry", rn, -rp);
    end

    // R10 most negative code
    run_op(-32768, 1'b0, res, lat);
    chk(iabs(res - (-16373)) <= 4, "R10 code -32768", res, -16373);
    chk(lat <= 26, "R8 latency at largest k", lat, 26);

    // R2 largest positive code
    run_op(32767, 1'b0, res, lat);
    check_val(32767, res, lat);

    // R6 input held busy with another code is ignored
    n_pulse = 0;
    n_acc = 0;
    run_op(4096, 1'b1, res, lat);
    chk(iabs(res - model(4096)) <= 4, "R6 busy input ignored", res, model(4096));
    chk(in_ready == 1'b1, "R6 ready back after result", int'(in_ready), 1);

    // R9 result held while idle
    hold = res;
    repeat (10) @(negedge clk);
    chk(int'($signed(out_data)) == hold, "R9 result held", int'($signed(out_data)), hold);
    chk(out_valid == 1'b0, "R7 no spurious pulse", int'(out_valid), 0);

    // R7 one pulse per accepted input
    chk(n_pulse == n_acc, "R7 pulse count", n_pulse, n_acc);

    finish_run();
  end

endmodule